// File: doc/BRIEF.md
# Button-Triggered Buzzer Pattern Sequencer

This block is the timing core of a one-shot notification device. A push button starts a single fixed-length activation window, provided the supply-good flag is high when the press is recognised. While the window is open, a divided square-wave tone drives the phase input of a full-bridge piezo stage. A fixed fourteen-step on/off pattern gates the bridge enable, so the device emits a short coded chirp and then goes quiet.

The inverse of the window serves as the system sleep control, which powers down the boost converter and the other helpers between activations. An over-current flag from the piezo current comparator forces the bridge enable low in the same cycle it is raised. The button is synchronised and edge-detected inside the block. Presses made while a window is open are discarded, and when a window closes the tone and pattern counters return to zero.

Top module: `buzz_pattern_seq`

## Requirements
- R1: While and immediately after reset, win_en_o is 0, sleep_o is 1, tone_o is 0 and bridge_en_o is 0.
- R2: The button passes through two synchroniser stages and a rising-edge detector. win_en_o first reads 1 in the cycle that follows the third rising clock edge after btn_i goes high. A button that is held high never opens a second window.
- R3: A press opens the window only if pwr_ok_i is high in the cycle where its edge is detected. Otherwise the press is dropped for good.
- R4: Once open, the window stays open for exactly PAT_LEN × STEP_CYCLES clock cycles. STEP_CYCLES is CLK_HZ × WINDOW_US / (10^6 × PAT_LEN), which is 62 500 cycles at the defaults.
- R5: Button edges that arrive while the window is open have no effect: the window neither restarts nor stretches.
- R6: In window cycle k (counting from 0), pattern step k / STEP_CYCLES is active. Step i uses PATTERN bit i, so bit 0 plays first. The default bit 0..13 order is 0,1,0,1,0,1,0,1,1,0,1,0,1,1, which is PATTERN = 14'b11010110101010.
- R7: bridge_en_o equals win_en_o AND the active pattern bit AND NOT ocp_i. ocp_i acts combinationally in the same cycle.
- R8: sleep_o is always the inverse of win_en_o.
- R9: In window cycle k, tone_o equals (k / HALF) mod 2, where HALF = CLK_HZ / (2 × TONE_HZ). tone_o is 0 whenever the window is closed.
- R10: Every window begins with the tone phase and the pattern step both at zero, so repeated activations produce identical waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Asynchronous push-button level |
| pwr_ok_i | input | 1 | Supply-good flag from the battery comparator |
| ocp_i | input | 1 | Piezo over-current flag |
| tone_o | output | 1 | Tone phase for the full bridge |
| bridge_en_o | output | 1 | Full-bridge enable |
| sleep_o | output | 1 | System sleep control, inverse of the window |
| win_en_o | output | 1 | Activation window enable |

## Verification
Several rules are checked by the assertions on every cycle. The bridge is only enabled inside a window with no over-current. A start needs supply-good and an idle window, and it always opens the window on the next cycle. The window never outlasts its length, the tone stays low when idle, and the step index is back at zero whenever the window closes. The bench scenarios are needed for the rest: the exact cycle-by-cycle pattern and tone values, the three-edge start latency, how a press made without supply-good or held across a supply change is handled, and whether a second activation replays the first exactly.

// File: rtl/buzz_seq_pkg.sv
package buzz_seq_pkg;

  // Clock cycles per half period of the tone.
  function automatic int unsigned tone_half_cycles(int unsigned clk_hz, int unsigned tone_hz);
    return clk_hz / (2 * tone_hz);
  endfunction

  // Clock cycles per pattern step: the window divided evenly over the steps.
  function automatic int unsigned step_cycles(int unsigned clk_hz, int unsigned window_us,
                                              int unsigned plen);
    longint unsigned prod;
    longint unsigned div;
    prod = 64'(clk_hz) * 64'(window_us);
    div  = 64'd1000000 * 64'(plen);
    return 32'(prod / div);
  endfunction

  // Width needed to count up to and including n.
  function automatic int unsigned count_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= btn_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], btn_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pattern_window.sv
module pattern_window #(
  parameter int unsigned PAT_LEN = 14,
  parameter int unsigned STEP    = 62500,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned STEP_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [STEP_W-1:0] step_q;
  logic              step_end;
  logic              last_step;

  assign step_end  = (step_q == STEP_W'(STEP - 1));
  assign last_step = (idx_o == IDX_W'(PAT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      step_q   <= '0;
    end else if (!active_o) begin
      step_q <= '0;
      idx_o  <= '0;
      if (start_i) active_o <= 1'b1;
    end else if (step_end) begin
      step_q <= '0;
      if (last_step) begin
        active_o <= 1'b0;
        idx_o    <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else begin
      step_q <= step_q + 1'b1;
    end
  end
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned HALF   = 200,
  parameter int unsigned HALF_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic phase_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              wrap;

  assign wrap = (cnt_q == HALF_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/buzz_pattern_seq.sv
module buzz_pattern_seq
  import buzz_seq_pkg::*;
#(
  parameter int unsigned      CLK_HZ      = 1_000_000,
  parameter int unsigned      TONE_HZ     = 2500,
  parameter int unsigned      WINDOW_US   = 875_000,
  parameter int unsigned      PAT_LEN     = 14,
  parameter logic [PAT_LEN-1:0] PATTERN   = 14'b11010110101010,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  input  logic pwr_ok_i,
  input  logic ocp_i,
  output logic tone_o,
  output logic bridge_en_o,
  output logic sleep_o,
  output logic win_en_o
);
  localparam int unsigned HALF       = tone_half_cycles(CLK_HZ, TONE_HZ);
  localparam int unsigned STEP       = step_cycles(CLK_HZ, WINDOW_US, PAT_LEN);
  localparam int unsigned WIN_CYCLES = STEP * PAT_LEN;
  localparam int unsigned IDX_W      = $clog2(PAT_LEN);
  localparam int unsigned STEP_W     = count_width(STEP);
  localparam int unsigned HALF_W     = count_width(HALF);

  // Named internal events, visible to the bound checker.
  logic             btn_rise;
  logic             start_evt;
  logic             active;
  logic [IDX_W-1:0] step_idx;
  logic             tone_q;
  logic             pat_bit;

  btn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .btn_i  (btn_i),
    .rise_o (btn_rise)
  );

  assign start_evt = btn_rise & pwr_ok_i & ~active;

  pattern_window #(
    .PAT_LEN (PAT_LEN),
    .STEP    (STEP),
    .IDX_W   (IDX_W),
    .STEP_W  (STEP_W)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_evt),
    .active_o (active),
    .idx_o    (step_idx)
  );

  tone_divider #(
    .HALF   (HALF),
    .HALF_W (HALF_W)
  ) u_tone (
    .clk     (clk),
    .rst     (rst),
    .run_i   (active),
    .phase_o (tone_q)
  );

  assign pat_bit     = PATTERN[step_idx];
  assign win_en_o    = active;
  assign sleep_o     = ~active;
  assign tone_o      = active & tone_q;
  assign bridge_en_o = active & pat_bit & ~ocp_i;
endmodule

// File: rtl/buzz_pattern_seq_chk.sv
module buzz_pattern_seq_chk #(
  parameter int unsigned PAT_LEN    = 14,
  parameter int unsigned WIN_CYCLES = 875000,
  parameter int unsigned IDX_W      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_ok_i,
  input logic             ocp_i,
  input logic             tone_o,
  input logic             bridge_en_o,
  input logic             win_en_o,
  input logic             start_evt,
  input logic [IDX_W-1:0] step_idx
);
  int unsigned open_cnt;

  always_ff @(posedge clk) begin
    if (rst || !win_en_o) open_cnt <= 0;
    else                  open_cnt <= open_cnt + 1;
  end

  assert_bridge_gated_R7: assert property (@(posedge clk) disable iff (rst)
    bridge_en_o |-> (win_en_o && !ocp_i));

  assert_start_needs_supply_R3: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> pwr_ok_i);

  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> !win_en_o);

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> win_en_o);

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
    win_en_o |-> (open_cnt < WIN_CYCLES));

  assert_tone_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !win_en_o |-> !tone_o);

  assert_index_range_R6: assert property (@(posedge clk) disable iff (rst)
    32'(step_idx) < PAT_LEN);

  assert_index_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(win_en_o) |-> (step_idx == '0));
endmodule

bind buzz_pattern_seq buzz_pattern_seq_chk #(
  .PAT_LEN    (PAT_LEN),
  .WIN_CYCLES (WIN_CYCLES),
  .IDX_W      (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_ok_i    (pwr_ok_i),
  .ocp_i       (ocp_i),
  .tone_o      (tone_o),
  .bridge_en_o (bridge_en_o),
  .win_en_o    (win_en_o),
  .start_evt   (start_evt),
  .step_idx    (step_idx)
);

// File: tb/buzz_pattern_seq_test.sv
module buzz_pattern_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 20000;
  localparam int T_TONE_HZ  = 2500;
  localparam int T_WIN_US   = 875000;
  localparam int T_STEPS    = 14;
  localparam int HALF_C     = T_CLK_HZ / T_TONE_HZ / 2;              // 4
  localparam int STEP_C     = (T_CLK_HZ / 1000) * (T_WIN_US / 1000) / T_STEPS; // 1250
  localparam int WIN_C      = STEP_C * T_STEPS;                        // 17500
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic pwr = 1'b1;
  logic ocp = 1'b0;
  logic tone, bridge, sleep_s, win;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Order of play, first step first.
  int seq_bits [T_STEPS] = '{0,1,0,1,0,1,0,1,1,0,1,0,1,1};

  buzz_pattern_seq #(
    .CLK_HZ    (T_CLK_HZ),
    .TONE_HZ   (T_TONE_HZ),
    .WINDOW_US (T_WIN_US)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .btn_i       (btn),
    .pwr_ok_i    (pwr),
    .ocp_i       (ocp),
    .tone_o      (tone),
    .bridge_en_o (bridge),
    .sleep_o     (sleep_s),
    .win_en_o    (win)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_tone(int k);
    return logic'((k / HALF_C) % 2);
  endfunction

  function automatic logic exp_bridge(int k, logic oc);
    return (seq_bits[k / STEP_C] != 0) && !oc;
  endfunction

  task automatic check(string req, logic got, logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_idle(string req);
    check({req, " win"}, win, 1'b0);
    check("R8 sleep idle", sleep_s, 1'b1);
    check("R9 tone idle", tone, 1'b0);
    check("R7 bridge idle", bridge, 1'b0);
  endtask

  task automatic run_window(bit rnd);
    @(negedge clk);
    btn = 1'b1;
    pwr = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      #1;
      check("R2 start latency", win, (i == 3) ? 1'b1 : 1'b0);
    end
    for (int k = 0; k < WIN_C; k++) begin
      if (k > 0) @(negedge clk);
      if (rnd) begin
        ocp = ($urandom % 4) == 0;
        btn = (k < WIN_C - 8) ? (($urandom % 8) == 0) : 1'b0;   // R5 presses mid-window
      end else begin
        ocp = 1'b0;
        if (k == 5) btn = 1'b0;
      end
      #1;
      check("R4 window open", win, 1'b1);
      check("R8 sleep active", sleep_s, 1'b0);
      check("R9 tone phase", tone, exp_tone(k));
      check(ocp ? "R7 ocp gating" : "R6 pattern bit", bridge, exp_bridge(k, ocp));
    end
    @(negedge clk);
    ocp = 1'b0;
    btn = 1'b0;
    #1;
    check_idle("R4 window closed");
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      #1;
      check("R5 no extra window", win, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_idle("R1 after reset");

    // Directed window with no disturbances.
    run_window(1'b0);

    // R3: press with supply low is dropped, and stays dropped.
    @(negedge clk);
    pwr = 1'b0;
    btn = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      #1;
      check("R3 no start without supply", win, 1'b0);
    end
    // R2: supply returns while the button is held; no edge, no window.
    pwr = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      #1;
      check("R2 held button no start", win, 1'b0);
    end
    btn = 1'b0;
    repeat (4) @(negedge clk);

    // Random over-current and mid-window presses.
    run_window(1'b1);

    // R10: a later activation replays the first one exactly.
    run_window(1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule